// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing protocol engine of a small serial EEPROM that answers on a two-wire bus. A fast system clock oversamples the clock and data lines. The engine finds start and stop conditions, checks the device-select byte against its select pins, takes in a word address, and serves byte writes, page writes, current-address reads, random reads and sequential reads. It drives the data line only as an open-drain pull-down enable.

The engine owns the word-address counter and reads from an external synchronous array of 128, 256 or 512 bytes, selected by a parameter. The array has one cycle of read latency. Write data is not stored here. Each received data byte is handed to a separate page-buffer block as a strobe carrying address and data. A stop condition then issues a commit pulse. The counter follows asymmetric rules: it steps past every byte that is read, and it stays on the written word address after a write. In the 512-byte build, one bit of the select byte becomes the ninth address bit.

Top module: `eep_slave_engine`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bytes clocked in before any start draw no acknowledge.
- R2: The select byte after a start is taken MSB first. Its bits 7:4 must be 1010, and bit 0 is read (1) or write (0). On a match, SDA is pulled low during the ninth clock. On a mismatch there is no acknowledge and the bus is ignored until the next start.
- R3: With MEM_BYTES=512, only select bits 3:2 are compared, with dev_sel_i[2:1]. Select bit 1 of a write-mode select byte becomes bit 8 of the word address. With smaller arrays, bits 3:1 are compared with dev_sel_i[2:0].
- R4: Every word-address byte and every write-data byte is acknowledged by pulling SDA low on its ninth clock.
- R5: Input bits are sampled on SCL rising. sda_oe_o changes only while SCL is low, after a falling edge, and it is 0 during and after reset.
- R6: Each received write-data byte produces a one-cycle wr_stb_o with wr_data_o and wr_addr_o. Successive addresses step through the low log2(page) bits and wrap inside the page (8 bytes, or 16 when MEM_BYTES=512), while the upper bits stay fixed.
- R7: wr_commit_o pulses for one cycle on a stop that ends a write in which at least one data byte was received. A start that arrives first cancels the commit.
- R8: Read data is sent MSB first. A low acknowledge from the master brings the next byte. A high acknowledge releases SDA and ends the read.
- R9: The counter is 0 after reset. A current read after a read returns the byte after the last one read. A current read after a write returns the byte at the written word address.
- R10: A write-mode select byte and a word address, followed by a repeated start and a read-mode select byte, return data from that word address.
- R11: During a sequential read the address wraps from the top word of the array to word 0.
- R12: A start in the middle of a byte abandons the operation and restarts select-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_sel_i | input | 3 | Device-select strap pins |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_raddr_o | output | AW | Read address to the array (the word-address counter) |
| mem_rdata_i | input | 8 | Array read data, one cycle after the address |
| wr_stb_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | AW | Target address of the strobed byte |
| wr_data_o | output | 8 | Strobed write byte |
| wr_commit_o | output | 1 | One-cycle pulse asking the page buffer to commit |

## Verification
The bench builds the engine with MEM_BYTES=512 and the select pins strapped to 101. This setting exercises the page-select bit as address bit 8, the 16-byte page wrap of write addresses, and the wrap from word 0x1FF to 0 during a sequential read. Because the 512-byte build compares only two select bits, the smaller builds' three-bit compare is exercised only through elaboration at the default size.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT
  } eep_state_e;
endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= 3'b111;
      sda_pipe <= 3'b111;
    end else begin
      scl_pipe <= {scl_pipe[1:0], scl_i};
      sda_pipe <= {sda_pipe[1:0], sda_i};
    end
  end

  // pipe[1] is the synchronized value, pipe[2] the one before it
  assign sda_s     = sda_pipe[1];
  assign scl_rise  = scl_pipe[1] & ~scl_pipe[2];
  assign scl_fall  = ~scl_pipe[1] & scl_pipe[2];
  assign start_det = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
  assign stop_det  = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] cnt
);
  logic [AW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld | inc;
    cnt_d  = ld ? ld_val : cnt + AW'(1);   // natural wrap at the array top
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/eep_page_addr.sv
module eep_page_addr #(
  parameter int AW = 8,
  parameter int PW = 3
) (
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] offset,
  output logic [AW-1:0] addr
);
  // upper bits fixed, low bits roll over inside the page
  assign addr = {base[AW-1:PW], PW'(base[PW-1:0] + offset)};
endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine #(
  parameter  int MEM_BYTES  = 256,
  localparam int AW         = $clog2(MEM_BYTES),
  localparam int PAGE_BYTES = (MEM_BYTES >= 512) ? 16 : 8,
  localparam int PW         = $clog2(PAGE_BYTES),
  localparam bit WIDE       = (AW > 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    dev_sel_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o
);
  import eep_pkg::*;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_bus_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_e    st_q, st_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          rw_q, rw_d, ps_q, ps_d, oe_q, oe_d;
  logic          pend_q, pend_d, mack_q, mack_d;
  logic          stb_q, stb_d, cmt_q, cmt_d;
  logic [7:0]    wdat_q, wdat_d;
  logic [AW-1:0] waddr_q, waddr_d;
  logic [PW-1:0] woff_q, woff_d;
  logic          ctr_ld, ctr_inc;
  logic [AW-1:0] ctr_val, ctr_q, page_addr;
  logic          dev_hit;

  eep_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld(ctr_ld), .ld_val(ctr_val),
    .inc(ctr_inc), .cnt(ctr_q)
  );

  eep_page_addr #(.AW(AW), .PW(PW)) u_pga (
    .base(ctr_q), .offset(woff_q), .addr(page_addr)
  );

  generate
    if (WIDE) begin : g_wide
      assign dev_hit = (sh_q[7:4] == 4'b1010) && (sh_q[3:2] == dev_sel_i[2:1]);
    end else begin : g_narrow
      assign dev_hit = (sh_q[7:4] == 4'b1010) && (sh_q[3:1] == dev_sel_i);
    end
  endgenerate

  always_comb begin
    st_d = st_q;  bit_d = bit_q;  sh_d = sh_q;  rw_d = rw_q;  ps_d = ps_q;
    oe_d = oe_q;  pend_d = pend_q;  mack_d = mack_q;
    wdat_d = wdat_q;  waddr_d = waddr_q;  woff_d = woff_q;
    stb_d = 1'b0;  cmt_d = 1'b0;  ctr_ld = 1'b0;  ctr_inc = 1'b0;
    ctr_val = AW'({ps_q, sh_q});
    if (start_det) begin
      st_d = ST_DEV;  bit_d = '0;  oe_d = 1'b0;  pend_d = 1'b0;
    end else if (stop_det) begin
      cmt_d = pend_q;  pend_d = 1'b0;  st_d = ST_IDLE;  oe_d = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) begin
          if (st_q != ST_RDAT) sh_d = {sh_q[6:0], sda_s};
        end else if (st_q == ST_RDAT) begin
          mack_d = sda_s;
        end
        bit_d = bit_q + 4'd1;
      end else if (scl_fall) begin
        case (bit_q)
          4'd8: begin                       // ninth clock begins
            case (st_q)
              ST_DEV: begin
                if (dev_hit) begin
                  oe_d = 1'b1;  rw_d = sh_q[0];  ps_d = WIDE ? sh_q[1] : 1'b0;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              ST_WADR: begin
                oe_d = 1'b1;  ctr_ld = 1'b1;  woff_d = '0;
              end
              ST_WDAT: begin
                oe_d = 1'b1;  stb_d = 1'b1;  wdat_d = sh_q;  waddr_d = page_addr;
                woff_d = woff_q + PW'(1);  pend_d = 1'b1;
              end
              default: oe_d = 1'b0;         // release for the master's ack
            endcase
          end
          4'd9: begin                       // ninth clock ends
            bit_d = '0;
            oe_d  = 1'b0;
            case (st_q)
              ST_DEV:  if (rw_q) begin
                         st_d = ST_RDAT;  sh_d = mem_rdata_i;
                         oe_d = ~mem_rdata_i[7];  ctr_inc = 1'b1;
                       end else begin
                         st_d = ST_WADR;
                       end
              ST_WADR: st_d = ST_WDAT;
              ST_RDAT: if (!mack_q) begin
                         sh_d = mem_rdata_i;  oe_d = ~mem_rdata_i[7];  ctr_inc = 1'b1;
                       end else begin
                         st_d = ST_IDLE;
                       end
              default: st_d = st_q;
            endcase
          end
          default: begin
            if (st_q == ST_RDAT && bit_q != 4'd0) begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  bit_q <= '0;  sh_q <= '0;  rw_q <= 1'b0;  ps_q <= 1'b0;
      oe_q <= 1'b0;  pend_q <= 1'b0;  mack_q <= 1'b1;  stb_q <= 1'b0;
      cmt_q <= 1'b0;  wdat_q <= '0;  waddr_q <= '0;  woff_q <= '0;
    end else begin
      st_q <= st_d;  bit_q <= bit_d;  sh_q <= sh_d;  rw_q <= rw_d;  ps_q <= ps_d;
      oe_q <= oe_d;  pend_q <= pend_d;  mack_q <= mack_d;  stb_q <= stb_d;
      cmt_q <= cmt_d;  wdat_q <= wdat_d;  waddr_q <= waddr_d;  woff_q <= woff_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_raddr_o = ctr_q;
  assign wr_stb_o    = stb_q;
  assign wr_addr_o   = waddr_q;
  assign wr_data_o   = wdat_q;
  assign wr_commit_o = cmt_q;
endmodule

// File: rtl/eep_slave_engine_chk.sv
module eep_slave_engine_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic [AW-1:0] mem_raddr_o,
  input logic          wr_stb_o,
  input logic          wr_commit_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_q <= 1'b0;
    else if (wr_stb_o)    seen_q <= 1'b1;
    else if (wr_commit_o) seen_q <= 1'b0;
  end

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);                                  // R5
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);                                         // R6
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |=> !wr_commit_o);                                   // R7
  AST_COMMIT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> seen_q);                                         // R7
  AST_STB_NOT_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_o && wr_commit_o));                                     // R7
  AST_CTR_HELD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $stable(mem_raddr_o));                              // R9
endmodule

bind eep_slave_engine eep_slave_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .mem_raddr_o(mem_raddr_o), .wr_stb_o(wr_stb_o), .wr_commit_o(wr_commit_o)
);

// File: tb/eep_slave_engine_test.sv
module eep_slave_engine_test;
  localparam int MEM = 512;
  localparam int AW  = 9;
  localparam int Q   = 20;

  logic          clk, rst_n, scl, m_low, sda_bus;
  logic          oe, stb, commit;
  logic [AW-1:0] raddr, waddr;
  logic [7:0]    rdata, wdata;
  int            n_chk = 0, n_fail = 0, n_stb = 0, n_cmt = 0;
  logic [8:0]    stb_addr [8];
  logic [7:0]    stb_data [8];
  bit            done = 0;

  // kind(1: current read) | word address | byte count | expected first address
  localparam logic [22:0] VEC [5] = '{
    {1'b0, 9'h005, 4'd3, 9'h005},
    {1'b1, 9'h000, 4'd2, 9'h008},
    {1'b0, 9'h1FE, 4'd4, 9'h1FE},
    {1'b1, 9'h000, 4'd1, 9'h002},
    {1'b0, 9'h180, 4'd1, 9'h180}
  };

  assign sda_bus = ~(m_low | oe);

  eep_slave_engine #(.MEM_BYTES(MEM)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .dev_sel_i(3'b101),
    .sda_oe_o(oe), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .wr_stb_o(stb), .wr_addr_o(waddr), .wr_data_o(wdata), .wr_commit_o(commit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_mem(input logic [8:0] a);
    return 8'(a * 29 + 7) ^ 8'(a >> 3);
  endfunction

  always_ff @(posedge clk) rdata <= exp_mem(raddr);

  always @(negedge clk) begin
    if (stb) begin
      if (n_stb < 8) begin
        stb_addr[n_stb] = waddr;
        stb_data[n_stb] = wdata;
      end
      n_stb = n_stb + 1;
    end
    if (commit) n_cmt = n_cmt + 1;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(input logic more, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; wq(); scl = 1'b1; wq(); d[i] = sda_bus; wq(); scl = 1'b0; wq();
    end
    put_bit(more ? 1'b0 : 1'b1);
  endtask

  task automatic run_read(input logic kind, input logic [8:0] a, input int n,
                          input logic [8:0] e);
    logic ack;
    logic [7:0] d;
    string tag;
    bus_start();
    if (!kind) begin
      put_byte({4'hA, 2'b10, a[8], 1'b0}, ack); check("R2 select ack", 16'(ack), 16'd0);
      put_byte(a[7:0], ack);                    check("R4 word ack", 16'(ack), 16'd0);
      bus_start();
    end
    put_byte({4'hA, 2'b10, a[8], 1'b1}, ack);   check("R2 read select ack", 16'(ack), 16'd0);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, d);
      if (i == 0)                     tag = kind ? "R9 current read" : (a[8] ? "R3 page bit" : "R10 random read");
      else if (10'(e) + 10'(i) >= 10'(MEM)) tag = "R11 wrap";
      else                            tag = "R8 sequential";
      check(tag, 16'(d), 16'(exp_mem(9'(e + 9'(i)))));
    end
    check("R8 release after nack", 16'(oe), 16'd0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 reset oe", 16'(oe), 16'd0);
    check("R9 reset counter", 16'(raddr), 16'd0);
    check("R7 reset commit", 16'(commit), 16'd0);
    rst_n = 1'b1;
    wq();
    scl = 1'b0; wq();

    // no start yet: a well-formed select byte is not acknowledged
    put_byte(8'hAA, ack); check("R1 no ack before start", 16'(ack), 16'd1);
    bus_stop();

    // stimulus table
    for (int v = 0; v < 5; v++)
      run_read(VEC[v][22], VEC[v][21:13], int'(VEC[v][12:9]), VEC[v][8:0]);

    // select mismatch: A1 set where pin is 0
    bus_start();
    put_byte(8'hA4, ack); check("R2 mismatch nack", 16'(ack), 16'd1);
    put_byte(8'h00, ack); check("R2 ignored after mismatch", 16'(ack), 16'd1);
    bus_stop();

    // page write at 0x13E with page-select set, three bytes wrap inside the page
    bus_start();
    put_byte(8'hAA, ack); check("R3 write select ack", 16'(ack), 16'd0);
    put_byte(8'h3E, ack); check("R4 word ack", 16'(ack), 16'd0);
    put_byte(8'h11, ack); check("R4 data ack 0", 16'(ack), 16'd0);
    put_byte(8'h22, ack); check("R4 data ack 1", 16'(ack), 16'd0);
    put_byte(8'h33, ack); check("R4 data ack 2", 16'(ack), 16'd0);
    check("R6 strobe count", 16'(n_stb), 16'd3);
    check("R7 no commit before stop", 16'(n_cmt), 16'd0);
    bus_stop();
    check("R7 commit on stop", 16'(n_cmt), 16'd1);
    check("R3 addr 0", 16'(stb_addr[0]), 16'h13E);
    check("R6 addr 1", 16'(stb_addr[1]), 16'h13F);
    check("R6 addr 2 page wrap", 16'(stb_addr[2]), 16'h130);
    check("R6 data 0", 16'(stb_data[0]), 16'h11);
    check("R6 data 2", 16'(stb_data[2]), 16'h33);

    // current read after the write returns the written word address itself
    bus_start();
    put_byte(8'hAB, ack); check("R2 read select ack", 16'(ack), 16'd0);
    get_byte(1'b0, d);    check("R9 read after write", 16'(d), 16'(exp_mem(9'h13E)));
    bus_stop();

    // write one byte, then a start in the middle of the next byte
    bus_start();
    put_byte(8'hA8, ack);
    put_byte(8'h20, ack);
    put_byte(8'h5A, ack);
    check("R6 single strobe addr", 16'(stb_addr[3]), 16'h020);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte(8'hAB, ack); check("R12 restart select ack", 16'(ack), 16'd0);
    get_byte(1'b0, d);    check("R12 data after abort", 16'(d), 16'(exp_mem(9'h020)));
    bus_stop();
    check("R7 commit cancelled by start", 16'(n_cmt), 16'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule